// File: doc/BRIEF.md
# Lockable Watchdog Timer

The block is a watchdog for a processor subsystem. A slow reference clock is divided down to a coarse counting tick. A 6-bit down-counter loaded from a programmable timeout code counts those ticks. Software must restart the count at regular intervals by writing a two-word key pair to a service register. If it does not, the counter runs out. The block then raises a reset request for one reference clock cycle and latches a timeout flag. It then reloads and keeps running, so missed services keep producing requests until the system reset generator acts.

The CPU owns the register file in its own clock domain. Control bits, the service event and the reference-domain status cross between the two clocks through multi-flop synchronizers. The remaining count is also readable, carried across in Gray code. Once the enable bit is set, it stays set until reset. Two further control bits let the power-mode inputs freeze the count: one covers doze and one covers stop. When the mode ends, counting continues from the frozen value.

Top module: `wdog_top`

## Requirements
- R1: After reset the control word (address 0) and the service word (address 1) both read 0, and reset_req stays low for as long as the enable bit has never been set.
- R2: With timeout code N in control bits [5:0], consecutive reset_req pulses with no service in between are exactly (N+1)·PRESCALE_DIV reference clock cycles apart, for every N from 0 to 63.
- R3: Control bit 6 is the enable. A control write with bit 6 at 0 does not clear an enable that is already set: bit 6 still reads 1 and expiries continue.
- R4: A write of 16'h5555 to address 1, followed by a write of 16'hAAAA as the next service write, reloads the prescaler and the counter, so regular key pairs prevent any reset_req. Address 1 reads back the last value written.
- R5: If any other value is written to address 1 between 16'h5555 and 16'hAAAA, no reload happens and the expiry spacing stays as in R2.
- R6: With control bit 7 set, each reference cycle in which doze_mode is high leaves the prescaler and counter unchanged, so the spacing of expiries grows by exactly that number of cycles.
- R7: With control bit 8 set, each reference cycle in which stop_mode is high freezes the count in the same way, lengthening the interval by the number of frozen cycles.
- R8: doze_mode has no effect while bit 7 is clear, and stop_mode has no effect while bit 8 is clear, whatever the other halt bit holds.
- R9: Each expiry drives reset_req high for exactly one reference cycle and sets control read bit 15. That bit stays set until reset.
- R10: Address 2 returns the remaining count in bits [5:0], synchronized into the CPU clock. While the count is frozen, repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | CPU register clock, at least as fast as ref_clk |
| ref_clk | input | 1 | Low-frequency reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bus_wr | input | 1 | Write strobe, one cpu_clk cycle per write |
| bus_addr | input | 2 | Register select: 0 control, 1 service, 2 count, 3 reads zero |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| doze_mode | input | 1 | Doze power mode, synchronous to ref_clk |
| stop_mode | input | 1 | Stop power mode, synchronous to ref_clk |
| reset_req | output | 1 | One-cycle reset request on expiry, ref_clk domain |

## Verification
The bench builds the block with PRESCALE_DIV = 8 and SYNC_STAGES = 2, with the reference clock at one quarter of the CPU clock. A divider of 8 makes the longest timeout code a 512-cycle interval, so both the shortest and the longest codes can be measured exactly between pulses. Halt windows of a known length also fit inside a single timeout. With two synchronizer stages, control changes and key pairs take effect within a few reference cycles, which is well inside a 32-cycle period. That margin lets service cadence and broken key sequences be told apart cleanly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int TMO_W  = 6;
  localparam int DATA_W = 16;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_SVC  = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_SECOND = 16'hAAAA;

  // packed so that tmo sits in [5:0], en in 6, doze halt in 7, stop halt in 8
  typedef struct packed {
    logic             stop_halt;
    logic             doze_halt;
    logic             en;
    logic [TMO_W-1:0] tmo;
  } wdog_ctl_t;

  localparam int CTRL_W = $bits(wdog_ctl_t);

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wdog_cpu_regs.sv
module wdog_cpu_regs
  import wdog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              flag_async,
  input  logic [TMO_W-1:0]  cnt_gray_async,
  output wdog_ctl_t         ctl_o,
  output logic              svc_tgl_o
);
  wdog_ctl_t  ctl_q, ctl_d, wr_ctl;
  logic [DATA_W-1:0] svc_q, svc_d;
  key_state_e key_q, key_d;
  logic       tgl_q, tgl_d;
  logic       flag_s;
  logic [TMO_W-1:0] gray_s, cnt_bin;

  wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_flag_sync (
    .clk(clk), .rst_n(rst_n), .d(flag_async), .q(flag_s));

  wdog_sync #(.W(TMO_W), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_gray_async), .q(gray_s));

  for (genvar i = 0; i < TMO_W; i++) begin : g_gray2bin
    assign cnt_bin[i] = ^(gray_s >> i);
  end

  assign wr_ctl = wdog_ctl_t'(bus_wdata[CTRL_W-1:0]);

  always_comb begin
    ctl_d = ctl_q;
    svc_d = svc_q;
    key_d = key_q;
    tgl_d = tgl_q;
    if (bus_wr && bus_addr == ADDR_CTRL) begin
      ctl_d.tmo       = wr_ctl.tmo;
      ctl_d.doze_halt = wr_ctl.doze_halt;
      ctl_d.stop_halt = wr_ctl.stop_halt;
      ctl_d.en        = ctl_q.en | wr_ctl.en;
    end
    if (bus_wr && bus_addr == ADDR_SVC) begin
      svc_d = bus_wdata;
      if (bus_wdata == KEY_FIRST) begin
        key_d = KEY_ARMED;
      end else begin
        key_d = KEY_IDLE;
        if (key_q == KEY_ARMED && bus_wdata == KEY_SECOND) tgl_d = ~tgl_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      svc_q <= '0;
      key_q <= KEY_IDLE;
      tgl_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      svc_q <= svc_d;
      key_q <= key_d;
      tgl_q <= tgl_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {flag_s, {(DATA_W-1-CTRL_W){1'b0}}, ctl_q};
      ADDR_SVC:  bus_rdata = svc_q;
      ADDR_CNT:  bus_rdata = {{(DATA_W-TMO_W){1'b0}}, cnt_bin};
      default:   bus_rdata = '0;
    endcase
  end

  assign ctl_o     = ctl_q;
  assign svc_tgl_o = tgl_q;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int PRESCALE_DIV = 16384,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdog_ctl_t        ctl_async,
  input  logic             svc_tgl_async,
  input  logic             doze_mode,
  input  logic             stop_mode,
  output logic             reset_req,
  output logic             flag_o,
  output logic [TMO_W-1:0] cnt_gray_o
);
  localparam int PRE_W = $clog2(PRESCALE_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE_DIV - 1);

  logic [CTRL_W-1:0] ctl_raw;
  wdog_ctl_t         ctl_s;
  logic              tgl_s, tgl_prev_q;
  logic              svc_pulse, halted, run, tick, expire;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [TMO_W-1:0]  cnt_q, cnt_d, gray_q, gray_d;
  logic              req_q, req_d, flag_q, flag_d;

  wdog_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_async), .q(ctl_raw));

  wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(clk), .rst_n(rst_n), .d(svc_tgl_async), .q(tgl_s));

  assign ctl_s     = wdog_ctl_t'(ctl_raw);
  assign svc_pulse = tgl_s ^ tgl_prev_q;
  assign halted    = (doze_mode & ctl_s.doze_halt) | (stop_mode & ctl_s.stop_halt);
  assign run       = ctl_s.en & ~halted;
  assign tick      = run & (pre_q == PRE_LAST);
  assign expire    = tick & (cnt_q == '0);

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    req_d  = 1'b0;
    flag_d = flag_q;
    if (!ctl_s.en || svc_pulse) begin
      pre_d = '0;
      cnt_d = ctl_s.tmo;
    end else begin
      if (run) pre_d = tick ? '0 : pre_q + 1'b1;
      if (expire) begin
        cnt_d  = ctl_s.tmo;
        req_d  = 1'b1;
        flag_d = 1'b1;
      end else if (tick) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    gray_d = cnt_d ^ (cnt_d >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      cnt_q      <= '0;
      gray_q     <= '0;
      req_q      <= 1'b0;
      flag_q     <= 1'b0;
      tgl_prev_q <= 1'b0;
    end else begin
      pre_q      <= pre_d;
      cnt_q      <= cnt_d;
      gray_q     <= gray_d;
      req_q      <= req_d;
      flag_q     <= flag_d;
      tgl_prev_q <= tgl_s;
    end
  end

  assign reset_req  = req_q;
  assign flag_o     = flag_q;
  assign cnt_gray_o = gray_q;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int PRESCALE_DIV = 16384,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        cpu_clk,
  input  logic        ref_clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        doze_mode,
  input  logic        stop_mode,
  output logic        reset_req
);
  logic             cpu_rst_n, ref_rst_n;
  wdog_ctl_t        ctl_cpu;
  logic             ctl_en_cpu;
  logic             svc_tgl;
  logic             flag_ref;
  logic [TMO_W-1:0] cnt_gray_ref;

  wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cpu_rst (
    .clk(cpu_clk), .rst_n(rst_n), .d(1'b1), .q(cpu_rst_n));

  wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n));

  wdog_cpu_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(cpu_clk), .rst_n(cpu_rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_async(flag_ref), .cnt_gray_async(cnt_gray_ref),
    .ctl_o(ctl_cpu), .svc_tgl_o(svc_tgl));

  wdog_core #(.PRESCALE_DIV(PRESCALE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_core (
    .clk(ref_clk), .rst_n(ref_rst_n),
    .ctl_async(ctl_cpu), .svc_tgl_async(svc_tgl),
    .doze_mode(doze_mode), .stop_mode(stop_mode),
    .reset_req(reset_req), .flag_o(flag_ref), .cnt_gray_o(cnt_gray_ref));

  assign ctl_en_cpu = ctl_cpu.en;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic cpu_clk,
  input logic ref_clk,
  input logic cpu_rst_n,
  input logic ref_rst_n,
  input logic en_cpu,
  input logic flag_ref,
  input logic reset_req
);
  // R9
  req_single_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    reset_req |=> !reset_req);

  // R9
  req_sets_flag_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    reset_req |-> flag_ref);

  // R9
  flag_sticky_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    flag_ref |=> flag_ref);

  // R3
  en_sticky_chk: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_n)
    en_cpu |=> en_cpu);

  // R1
  idle_quiet_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !en_cpu |-> !reset_req);
endmodule

bind wdog_top wdog_chk u_chk (
  .cpu_clk(cpu_clk), .ref_clk(ref_clk),
  .cpu_rst_n(cpu_rst_n), .ref_rst_n(ref_rst_n),
  .en_cpu(ctl_en_cpu), .flag_ref(flag_ref), .reset_req(reset_req));

// File: tb/wdog_top_tb.sv
module wdog_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_RATIO  = 4;
  localparam int DIV        = 8;
  localparam int HALT_LEN   = 20;

  logic        cpu_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic        bus_wr  = 1'b0;
  logic [1:0]  bus_addr  = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        doze_mode = 1'b0;
  logic        stop_mode = 1'b0;
  logic        reset_req;

  always #(CLK_PERIOD/2) cpu_clk = ~cpu_clk;
  always #(CLK_PERIOD*REF_RATIO/2) ref_clk = ~ref_clk;

  wdog_top #(.PRESCALE_DIV(DIV), .SYNC_STAGES(2)) u_dut (
    .cpu_clk(cpu_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .doze_mode(doze_mode), .stop_mode(stop_mode), .reset_req(reset_req));

  typedef struct {int val; string tag;} exp_t;
  exp_t exp_q[$];
  exp_t head;
  int n_cmp = 0, n_bad = 0;
  int since = 0, pulses = 0, wide = 0;
  logic prev_req = 1'b0;

  function automatic void check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  function automatic int period(int code);
    return (code + 1) * DIV;
  endfunction

  // monitor: measures spacing of reset requests and compares against the queue
  always @(negedge ref_clk) begin
    if (rst_n) begin
      if (reset_req && prev_req) wide++;
      prev_req = reset_req;
      if (reset_req) begin
        if (exp_q.size() > 0) begin
          head = exp_q.pop_front();
          check(head.tag, since + 1, head.val);
        end
        since = 0;
        pulses++;
      end else begin
        since++;
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    #1;
    @(negedge cpu_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge cpu_clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    #1;
    @(negedge cpu_clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_ctrl(input int code, input bit en, input bit dz, input bit st);
    bus_write(2'd0, {7'b0, st, dz, en, 6'(code)});
  endtask

  task automatic wait_pulses(input int k);
    int start;
    start = pulses;
    wait (pulses >= start + k);
  endtask

  task automatic expect_gap(input int v, input string tag);
    exp_q.push_back('{v, tag});
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
  endtask

  // one halt window of HALT_LEN reference cycles starting 5 cycles after a pulse
  task automatic halt_window(input bit use_doze, input int gap, input string tag);
    wait_pulses(1);
    expect_gap(gap, tag);
    repeat (5) @(negedge ref_clk);
    if (use_doze) doze_mode = 1'b1; else stop_mode = 1'b1;
    repeat (HALT_LEN) @(negedge ref_clk);
    doze_mode = 1'b0;
    stop_mode = 1'b0;
    drain();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge cpu_clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] rd, rd2;
    int p0;

    repeat (5) @(negedge cpu_clk);
    rst_n = 1'b1;
    repeat (5) @(negedge cpu_clk);

    // R1: reset state
    bus_read(2'd0, rd);
    check("R1 control reset", int'(rd), 0);
    bus_read(2'd1, rd);
    check("R1 service reset", int'(rd), 0);
    repeat (100) @(negedge ref_clk);
    check("R1 no request while disabled", pulses, 0);

    // R2: code 3
    set_ctrl(3, 1'b1, 1'b0, 1'b0);
    wait_pulses(1);
    expect_gap(period(3), "R2 code 3");
    expect_gap(period(3), "R2 code 3 repeat");
    drain();

    // R9: sticky flag in bit 15
    bus_read(2'd0, rd);
    check("R9 flag and control readback", int'(rd), 'h8043);

    // R3: enable cannot be cleared
    set_ctrl(3, 1'b0, 1'b0, 1'b0);
    bus_read(2'd0, rd);
    check("R3 enable bit still set", int'(rd[6]), 1);
    wait_pulses(1);
    expect_gap(period(3), "R3 expiries continue");
    drain();

    // R2: shortest and longest codes
    set_ctrl(0, 1'b1, 1'b0, 1'b0);
    wait_pulses(2);
    expect_gap(period(0), "R2 code 0");
    expect_gap(period(0), "R2 code 0 repeat");
    drain();
    set_ctrl(63, 1'b1, 1'b0, 1'b0);
    wait_pulses(2);
    expect_gap(period(63), "R2 code 63");
    drain();
    set_ctrl(3, 1'b1, 1'b0, 1'b0);
    wait_pulses(2);

    // R4: regular key pairs hold off expiry
    p0 = pulses;
    for (int i = 0; i < 20; i++) begin
      bus_write(2'd1, 16'h5555);
      bus_write(2'd1, 16'hAAAA);
      repeat (10) @(negedge ref_clk);
    end
    check("R4 no request while serviced", pulses - p0, 0);
    bus_read(2'd1, rd);
    check("R4 service readback", int'(rd), 'hAAAA);

    // R5: broken key sequences do not reload
    wait_pulses(1);
    for (int i = 0; i < 6; i++) expect_gap(period(3), "R5 broken key pair");
    p0 = pulses;
    for (int i = 0; i < 20; i++) begin
      bus_write(2'd1, 16'h5555);
      bus_write(2'd1, 16'h1234);
      bus_write(2'd1, 16'hAAAA);
      repeat (10) @(negedge ref_clk);
    end
    check("R5 requests kept coming", (pulses - p0 >= 5) ? 1 : 0, 1);
    drain();

    // R6 and R10: doze halt with its bit set, count read while frozen
    set_ctrl(3, 1'b1, 1'b1, 1'b0);
    wait_pulses(1);
    wait_pulses(1);
    expect_gap(period(3) + HALT_LEN, "R6 doze halt extends interval");
    repeat (5) @(negedge ref_clk);
    doze_mode = 1'b1;
    fork
      begin
        repeat (HALT_LEN) @(negedge ref_clk);
        doze_mode = 1'b0;
      end
      begin
        repeat (4) @(negedge ref_clk);
        bus_read(2'd2, rd);
        repeat (8) @(negedge ref_clk);
        bus_read(2'd2, rd2);
      end
    join
    check("R10 frozen count value", int'(rd), 3);
    check("R10 count stable while frozen", int'(rd2), int'(rd));
    drain();

    // R8: doze without its bit
    set_ctrl(3, 1'b1, 1'b0, 1'b0);
    wait_pulses(2);
    halt_window(1'b1, period(3), "R8 doze ignored without bit");

    // R7: stop halt with its bit set
    set_ctrl(3, 1'b1, 1'b0, 1'b1);
    wait_pulses(2);
    halt_window(1'b0, period(3) + HALT_LEN, "R7 stop halt extends interval");

    // R8: doze with only the stop bit set
    halt_window(1'b1, period(3), "R8 doze ignored with only stop bit");

    // R9: one-cycle requests, flag still set
    check("R9 request width one cycle", wide, 0);
    bus_read(2'd0, rd);
    check("R9 flag stays set", int'(rd[15]), 1);

    finish_run();
  end
endmodule